// File: doc/BRIEF.md
# Register File with Protected Entries

This block holds the 32 general registers of a small processor, each 32 bits wide. Two read ports, each addressed by 5 bits, return register contents combinationally. One write port takes an address, a data word and an enable, and updates the addressed register on the rising clock edge. The write address and the write-back data are chosen outside the block.

Four entries are protected. Entry 0 always reads zero. Entry 29 always reads the stack base constant (0x000000FC by default). Entries 27 and 28 hold the low and high words of a multiply or divide result. The general write port can change none of these four entries. Entries 27 and 28 are loaded only from two dedicated 32-bit result buses, under their own load strobe. All other entries are ordinary storage, and reset clears them.

Top module: `gprFile`

## Requirements
- R1: While reset (rstN low) is held and after it is released, every entry except 29 reads 0 until it is written, and entry 29 reads the stack constant.
- R2: When wrEn is high at a rising edge and wrAddr is a general entry (any address except 0, 27, 28 and 29), that entry reads wrData from that edge on.
- R3: When wrEn and resEn are both low at a rising edge, no entry changes.
- R4: Entry 0 reads 0 at all times, and a write to it has no effect.
- R5: Entry 29 reads the parameter SP_BASE (default 0x000000FC) at all times, and a write to it has no effect.
- R6: A general-port write addressed to entry 27 or entry 28 leaves both entries unchanged.
- R7: When resEn is high at a rising edge, entry 27 takes resLo and entry 28 takes resHi. This holds even if the general port targets one of them in the same cycle.
- R8: The rs and rt ports read any two entries independently in the same cycle, including the same entry on both ports.
- R9: A read of the entry being written in the same cycle returns the old contents until the clock edge, and the new contents after it.
- R10: A general write changes only the addressed entry. Every other entry keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rsAddr | input | 5 | Address of the first read port |
| rtAddr | input | 5 | Address of the second read port |
| rsData | output | 32 | Contents of entry rsAddr |
| rtData | output | 32 | Contents of entry rtAddr |
| wrEn | input | 1 | General write enable |
| wrAddr | input | 5 | General write address |
| wrData | input | 32 | General write data |
| resEn | input | 1 | Result load strobe for entries 27 and 28 |
| resLo | input | 32 | Low result word, loaded into entry 27 |
| resHi | input | 32 | High result word, loaded into entry 28 |

## Verification
The hardest case to reach is a cycle where both writers compete for a result entry: the general port aims at 27 or 28 while resEn loads both. The stimulus builds this cycle on purpose and then reads both entries back through the two read ports in a single cycle. A second difficult case is the read of an entry while that same entry is being written. The bench samples the read port in the half cycle before the edge and again after it, so it sees both the old and the new value.

// File: rtl/gprPkg.sv
package gprPkg;
  parameter int DATA_W    = 32;
  parameter int ADDR_W    = 5;
  localparam int REG_COUNT = 1 << ADDR_W;

  typedef struct packed {
    logic [REG_COUNT-1:0] wrHot;   // one-hot general write strobe
    logic                 resLoad; // result pair load strobe
  } gprStrobe_t;
endpackage

// File: rtl/gprCtrl.sv
module gprCtrl
  import gprPkg::*;
#(
  parameter int ZERO_IDX = 0,
  parameter int LO_IDX   = 27,
  parameter int HI_IDX   = 28,
  parameter int SP_IDX   = 29
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              resEn,
  output gprStrobe_t        strobe
);
  for (genvar i = 0; i < REG_COUNT; i++) begin : g_dec
    if (i == ZERO_IDX || i == LO_IDX || i == HI_IDX || i == SP_IDX) begin : g_locked
      assign strobe.wrHot[i] = 1'b0;
    end else begin : g_open
      assign strobe.wrHot[i] = wrEn && (wrAddr == ADDR_W'(i));
    end
  end
  assign strobe.resLoad = resEn;
endmodule

// File: rtl/gprStore.sv
module gprStore
  import gprPkg::*;
#(
  parameter int          ZERO_IDX = 0,
  parameter int          LO_IDX   = 27,
  parameter int          HI_IDX   = 28,
  parameter int          SP_IDX   = 29,
  parameter [DATA_W-1:0] SP_BASE  = 32'h0000_00FC
) (
  input  logic              clk,
  input  logic              rstN,
  input  gprStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] resLo,
  input  logic [DATA_W-1:0] resHi,
  input  logic [ADDR_W-1:0] rsAddr,
  input  logic [ADDR_W-1:0] rtAddr,
  output logic [DATA_W-1:0] rsData,
  output logic [DATA_W-1:0] rtData
);
  logic [DATA_W-1:0] regVal [REG_COUNT];
  logic unusedStrobes;

  assign unusedStrobes = strobe.wrHot[ZERO_IDX] ^ strobe.wrHot[SP_IDX];

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    if (i == ZERO_IDX) begin : g_zero
      assign regVal[i] = '0;
    end else if (i == SP_IDX) begin : g_sp
      assign regVal[i] = SP_BASE;
    end else if (i == LO_IDX || i == HI_IDX) begin : g_res
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regVal[i] <= '0;
        else if (strobe.resLoad) regVal[i] <= (i == LO_IDX) ? resLo : resHi;
        else if (strobe.wrHot[i]) regVal[i] <= wrData;
      end
    end else begin : g_gen
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regVal[i] <= '0;
        else if (strobe.wrHot[i]) regVal[i] <= wrData;
      end
    end
  end

  assign rsData = regVal[rsAddr];
  assign rtData = regVal[rtAddr];
endmodule

// File: rtl/gprFile.sv
module gprFile
  import gprPkg::*;
#(
  parameter int          ZERO_IDX = 0,
  parameter int          LO_IDX   = 27,
  parameter int          HI_IDX   = 28,
  parameter int          SP_IDX   = 29,
  parameter [DATA_W-1:0] SP_BASE  = 32'h0000_00FC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rsAddr,
  input  logic [ADDR_W-1:0] rtAddr,
  output logic [DATA_W-1:0] rsData,
  output logic [DATA_W-1:0] rtData,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              resEn,
  input  logic [DATA_W-1:0] resLo,
  input  logic [DATA_W-1:0] resHi
);
  gprStrobe_t strobe;

  gprCtrl #(.ZERO_IDX(ZERO_IDX), .LO_IDX(LO_IDX), .HI_IDX(HI_IDX), .SP_IDX(SP_IDX)) i_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .resEn(resEn), .strobe(strobe)
  );

  gprStore #(.ZERO_IDX(ZERO_IDX), .LO_IDX(LO_IDX), .HI_IDX(HI_IDX), .SP_IDX(SP_IDX),
             .SP_BASE(SP_BASE)) i_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .resLo(resLo), .resHi(resHi), .rsAddr(rsAddr), .rtAddr(rtAddr),
    .rsData(rsData), .rtData(rtData)
  );
endmodule

// File: rtl/gprChecker.sv
module gprChecker
  import gprPkg::*;
#(
  parameter int          ZERO_IDX = 0,
  parameter int          LO_IDX   = 27,
  parameter int          HI_IDX   = 28,
  parameter int          SP_IDX   = 29,
  parameter [DATA_W-1:0] SP_BASE  = 32'h0000_00FC
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] rsAddr,
  input logic [ADDR_W-1:0] rtAddr,
  input logic [DATA_W-1:0] rsData,
  input logic [DATA_W-1:0] rtData,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              resEn,
  input logic [DATA_W-1:0] resLo,
  input logic [DATA_W-1:0] resHi
);
  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else pastOk <= 1'b1;
  end

  function automatic logic isOpen(input logic [ADDR_W-1:0] a);
    return a != ADDR_W'(ZERO_IDX) && a != ADDR_W'(LO_IDX) &&
           a != ADDR_W'(HI_IDX) && a != ADDR_W'(SP_IDX);
  endfunction

  AST_ZERO_RS: assert property (@(posedge clk) disable iff (!rstN)
    rsAddr == ADDR_W'(ZERO_IDX) |-> rsData == '0); // R4
  AST_ZERO_RT: assert property (@(posedge clk) disable iff (!rstN)
    rtAddr == ADDR_W'(ZERO_IDX) |-> rtData == '0); // R4
  AST_SP_CONST: assert property (@(posedge clk) disable iff (!rstN)
    rsAddr == ADDR_W'(SP_IDX) |-> rsData == SP_BASE); // R5
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $past(wrEn) && isOpen($past(wrAddr)) && rsAddr == $past(wrAddr)
      |-> rsData == $past(wrData)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && !$past(wrEn) && !$past(resEn) && rtAddr == $past(rtAddr)
      |-> $stable(rtData)); // R3
  AST_RES_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && !$past(resEn) && rsAddr == ADDR_W'(LO_IDX) && $past(rsAddr) == ADDR_W'(LO_IDX)
      |-> $stable(rsData)); // R6
  AST_RES_LO: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $past(resEn) && rsAddr == ADDR_W'(LO_IDX) |-> rsData == $past(resLo)); // R7
  AST_RES_HI: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $past(resEn) && rtAddr == ADDR_W'(HI_IDX) |-> rtData == $past(resHi)); // R7
endmodule

bind gprFile gprChecker #(
  .ZERO_IDX(ZERO_IDX), .LO_IDX(LO_IDX), .HI_IDX(HI_IDX), .SP_IDX(SP_IDX), .SP_BASE(SP_BASE)
) i_gprChecker (
  .clk(clk), .rstN(rstN), .rsAddr(rsAddr), .rtAddr(rtAddr), .rsData(rsData),
  .rtData(rtData), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .resEn(resEn),
  .resLo(resLo), .resHi(resHi)
);

// File: tb/test_gprFile.sv
module test_gprFile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  rsAddr = '0, rtAddr = '0, wrAddr = '0;
  logic [31:0] rsData, rtData, wrData = '0, resLo = '0, resHi = '0;
  logic        wrEn = 1'b0, resEn = 1'b0;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] model [32];

  always #5 clk = ~clk;

  gprFile i_gprFile (
    .clk(clk), .rstN(rstN), .rsAddr(rsAddr), .rtAddr(rtAddr), .rsData(rsData),
    .rtData(rtData), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .resEn(resEn),
    .resLo(resLo), .resHi(resHi)
  );

  function automatic logic [31:0] expOf(input int a);
    if (a == 0) return 32'h0;
    if (a == 29) return 32'h0000_00FC;
    return model[a];
  endfunction

  function automatic logic [31:0] pat(input int a, input int k);
    return 32'h5A00_0000 ^ (32'(a) * 32'h0101_0101) ^ (32'(k) << 20);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readPair(input string req, input int a, input int b);
    @(negedge clk);
    rsAddr = 5'(a); rtAddr = 5'(b);
    #1;
    check(req, rsData, expOf(a));
    check(req, rtData, expOf(b));
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 32; i++) readPair(req, i, 31 - i);
  endtask

  task automatic doWrite(input int a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (a != 0 && a != 27 && a != 28 && a != 29) model[a] = d;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    #1;
    check("R1 in reset", rsData, 32'h0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    sweep("R1 reset state");

    for (int i = 0; i < 32; i++) doWrite(i, pat(i, 1));
    sweep("R2/R4/R5/R6 full write sweep");
    for (int i = 0; i < 32; i++) readPair("R8 same entry on both ports", i, i);

    // R3: data and address wiggle with enable low
    @(negedge clk);
    wrEn = 1'b0; wrAddr = 5'd5; wrData = 32'hDEAD_BEEF;
    resLo = 32'h1111_1111; resHi = 32'h2222_2222;
    @(negedge clk);
    sweep("R3 enables low");

    // R10: one write, all others untouched
    doWrite(12, 32'hC0DE_0012);
    sweep("R10 single write isolation");

    // R4/R5/R6 explicit protected writes
    doWrite(0, 32'hFFFF_FFFF);
    doWrite(29, 32'h1234_5678);
    doWrite(27, 32'hAAAA_AAAA);
    doWrite(28, 32'hBBBB_BBBB);
    readPair("R4/R5 protected after write", 0, 29);
    readPair("R6 result pair after general write", 27, 28);

    // R7: result load, then load racing a general write to entry 27
    @(negedge clk);
    resEn = 1'b1; resLo = 32'h0000_9D80; resHi = 32'h0000_0022;
    @(negedge clk);
    resEn = 1'b0;
    model[27] = 32'h0000_9D80; model[28] = 32'h0000_0022;
    readPair("R7 result load", 27, 28);
    @(negedge clk);
    resEn = 1'b1; resLo = 32'h7777_0001; resHi = 32'h7777_0002;
    wrEn = 1'b1; wrAddr = 5'd27; wrData = 32'hBAD0_BAD0;
    @(negedge clk);
    resEn = 1'b0; wrEn = 1'b0;
    model[27] = 32'h7777_0001; model[28] = 32'h7777_0002;
    readPair("R7 result load wins over general port", 27, 28);

    // R9: read during write
    for (int a = 1; a < 27; a += 5) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = 5'(a); wrData = pat(a, 9); rsAddr = 5'(a); rtAddr = 5'(a);
      #1;
      check("R9 old value before edge", rsData, model[a]);
      @(negedge clk);
      wrEn = 1'b0;
      model[a] = pat(a, 9);
      #1;
      check("R9 new value after edge", rtData, model[a]);
    end
    sweep("R2/R10 final sweep");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule